// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block executes the three vector configuration instructions. The instructions share one major opcode and one function code. From the instruction word and the values of the two scalar source registers, the unit works out three things: the requested element format, the application vector length (AVL), and the resulting vector length. It keeps the active vector length (`vl`) and the active element format (`vtype`) as architectural state. It also returns the new length so the pipeline can write it back to the destination register.

The unit finds the largest legal length, VLMAX, from the configured vector register width, the element width and the register grouping factor. The grouping factor may be fractional. The new length is the smaller of the AVL and VLMAX. If a requested format is not supported, the unit records a special "unsupported" format and sets the length to zero. State changes only on a clock edge where the valid strobe is high and the word decodes as a configuration instruction.

Top module: `vcfg_unit`

## Requirements
- R1: A word is accepted only when bits 6:0 are 1010111, bits 14:12 are 111, and the top bits match one of the three forms below. Any other word leaves `cfg_hit_o` and `rd_we_o` low, and `vl_o` and `vtype_o` keep their values.
- R2: When bit 31 is 0, the requested format is the zero-extended 11-bit field in bits 30:20, and the AVL is chosen by R5–R7.
- R3: When bits 31:30 are 11, the AVL is bits 19:15 zero-extended (0 to 31), and the requested format is the zero-extended 10-bit field in bits 29:20.
- R4: When bits 31:25 are 1000000, the requested format is the full value of `rs2_val_i`, and the AVL is chosen by R5–R7.
- R5: In the forms of R2 and R4, a nonzero source index in bits 19:15 makes the AVL equal to `rs1_val_i`.
- R6: In the forms of R2 and R4, a zero source index with a nonzero destination index (bits 11:7) makes the AVL all ones, so the new length equals VLMAX.
- R7: In the forms of R2 and R4, zero source and destination indices make the AVL the current `vl_o`. The new length is min(current vl, VLMAX), so it is unchanged whenever VLMAX is not smaller.
- R8: The format fields are: grouping code in bits 2:0, element-width code in bits 5:3 with SEW = 8 << code, and tail and mask policy flags in bits 6 and 7. VLMAX = VLEN × LMUL / SEW, where LMUL = 2^code for codes 0–3 and codes 5, 6 and 7 mean 1/2, 1/4 and 1/8. The new length is min(AVL, VLMAX).
- R9: A requested format is unsupported when any of these holds: a bit above bit 7 is set, the width code is above 3, the grouping code is 4, or SEW > LMUL × ELEN. In that case `vtype_o` becomes only its most significant bit set, and the new length is 0.
- R10: On a clock edge with `valid_i` high and an accepted word, `vl_o` takes the new length and `vtype_o` takes the new format. `rd_wdata_o` shows that same new length combinationally, and `rd_we_o` is high. With `valid_i` low, nothing changes.
- R11: While `rst_n` is low, `vl_o` is 0 and `vtype_o` has only its most significant bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Instruction present this cycle |
| instr_i | input | 32 | Instruction word |
| rs1_val_i | input | XLEN | Value of the source register named in bits 19:15 |
| rs2_val_i | input | XLEN | Value of the source register named in bits 24:20 |
| cfg_hit_o | output | 1 | Word decodes as a configuration instruction |
| rd_we_o | output | 1 | Destination write enable |
| rd_idx_o | output | 5 | Destination register index |
| rd_wdata_o | output | XLEN | New vector length for writeback |
| vl_o | output | XLEN | Active vector length |
| vtype_o | output | XLEN | Active element format |

## Verification
The keep-length case is the one where two functions share a cycle. In that cycle the AVL is read from the `vl` register while the same edge writes `vl` and `vtype` again. The bench provokes it by issuing keep-length instructions back to back, with `valid_i` held high, straight after instructions that set a different length. It changes the format in between, so VLMAX both shrinks and grows. Each result is judged against a bench model that tracks its own copy of the length. The bench checks both the combinational writeback value and the state registered on the following edge.

// File: rtl/vcfg_pkg.sv
// Shared constants and types for the vector configuration unit.
// Assumes 32-bit instruction words.
package vcfg_pkg;
    localparam logic [6:0] VCFG_OPCODE = 7'b1010111;
    localparam logic [2:0] VCFG_FUNCT3 = 3'b111;

    typedef enum logic [1:0] {
        FORM_NONE,
        FORM_REG_IMM,   // register AVL, immediate format
        FORM_IMM_IMM,   // immediate AVL, immediate format
        FORM_REG_REG    // register AVL, register format
    } vcfg_form_e;

    typedef enum logic [1:0] {
        AVL_SRC_REG,
        AVL_SRC_IMM,
        AVL_SRC_MAX,
        AVL_SRC_KEEP
    } vcfg_avl_e;
endpackage

// File: rtl/vcfg_decode.sv
// Decodes a configuration instruction and produces the requested
// format word and the AVL. Purely combinational. Assumes XLEN >= 11.
module vcfg_decode
    import vcfg_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [31:0]     instr_i,
    input  logic [XLEN-1:0] rs1_val_i,
    input  logic [XLEN-1:0] rs2_val_i,
    input  logic [XLEN-1:0] cur_vl_i,
    output logic            hit_o,
    output logic [XLEN-1:0] avl_o,
    output logic [XLEN-1:0] req_vtype_o,
    output logic [4:0]      rd_idx_o
);
    vcfg_form_e  form;
    vcfg_avl_e   avl_src;
    logic [4:0]  rs1_idx;

    assign rs1_idx  = instr_i[19:15];
    assign rd_idx_o = instr_i[11:7];

    // Classify the word into one of the three forms.
    always_comb begin
        form = FORM_NONE;
        if (instr_i[6:0] == VCFG_OPCODE && instr_i[14:12] == VCFG_FUNCT3) begin
            if (!instr_i[31])
                form = FORM_REG_IMM;
            else if (instr_i[30])
                form = FORM_IMM_IMM;
            else if (instr_i[29:25] == 5'd0)
                form = FORM_REG_REG;
        end
    end

    assign hit_o = (form != FORM_NONE);

    // Pick the AVL source from the form and the register indices.
    always_comb begin
        if (form == FORM_IMM_IMM)
            avl_src = AVL_SRC_IMM;
        else if (rs1_idx != 5'd0)
            avl_src = AVL_SRC_REG;
        else if (rd_idx_o != 5'd0)
            avl_src = AVL_SRC_MAX;
        else
            avl_src = AVL_SRC_KEEP;
    end

    // Produce the AVL value.
    always_comb begin
        unique case (avl_src)
            AVL_SRC_REG: avl_o = rs1_val_i;
            AVL_SRC_IMM: avl_o = {{(XLEN-5){1'b0}}, rs1_idx};
            AVL_SRC_MAX: avl_o = '1;
            default:     avl_o = cur_vl_i;
        endcase
    end

    // Produce the requested format word.
    always_comb begin
        unique case (form)
            FORM_REG_IMM: req_vtype_o = {{(XLEN-11){1'b0}}, instr_i[30:20]};
            FORM_IMM_IMM: req_vtype_o = {{(XLEN-10){1'b0}}, instr_i[29:20]};
            FORM_REG_REG: req_vtype_o = rs2_val_i;
            default:      req_vtype_o = '0;
        endcase
    end
endmodule

// File: rtl/vcfg_vlmax.sv
// Checks a requested format for support and computes VLMAX with shifts.
// Assumes VLEN, ELEN and SEW are powers of two and VLEN*8 fits in 32 bits.
module vcfg_vlmax #(
    parameter int XLEN = 32,
    parameter int VLEN = 128,
    parameter int ELEN = 32
) (
    input  logic [XLEN-9:0] vtype_hi_i,
    input  logic [2:0]      vsew_i,
    input  logic [2:0]      vlmul_i,
    output logic            legal_o,
    output logic [XLEN-1:0] vlmax_o
);
    localparam logic [31:0] VLEN_W = 32'(VLEN);
    localparam logic [31:0] ELEN_W = 32'(ELEN);

    logic [31:0] sew_w;
    logic [31:0] lhs;
    logic [31:0] rhs;
    logic [31:0] vlmax_w;
    logic [1:0]  mag;

    assign mag   = vlmul_i[1:0];
    assign sew_w = 32'd8 << vsew_i;

    // Width-versus-grouping comparison and VLMAX for whole or fractional LMUL.
    always_comb begin
        if (vlmul_i[2]) begin
            lhs     = sew_w << mag;
            rhs     = ELEN_W;
            vlmax_w = VLEN_W >> (32'(mag) + 32'd3 + 32'(vsew_i));
        end else begin
            lhs     = sew_w;
            rhs     = ELEN_W << mag;
            vlmax_w = (VLEN_W << mag) >> (32'd3 + 32'(vsew_i));
        end
    end

    // Combine the reserved-field and width checks.
    assign legal_o = (vtype_hi_i == '0) && (vsew_i <= 3'd3) &&
                     (vlmul_i != 3'd4) && (lhs <= rhs);
    assign vlmax_o = XLEN'(vlmax_w);
endmodule

// File: rtl/vcfg_state.sv
// Holds the active vector length and format. Synchronous active-low reset.
module vcfg_state #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic [XLEN-1:0] vl_d_i,
    input  logic [XLEN-1:0] vtype_d_i,
    output logic [XLEN-1:0] vl_q_o,
    output logic [XLEN-1:0] vtype_q_o
);
    localparam logic [XLEN-1:0] VT_RESET = {1'b1, {(XLEN-1){1'b0}}};

    // Register update on an accepted instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vl_q_o    <= '0;
            vtype_q_o <= VT_RESET;
        end else if (we_i) begin
            vl_q_o    <= vl_d_i;
            vtype_q_o <= vtype_d_i;
        end
    end
endmodule

// File: rtl/vcfg_unit.sv
// Top of the vector configuration unit: decode, VLMAX, clamp, state.
// Assumes the caller presents register values matching the indices in
// the instruction word in the same cycle as valid_i.
module vcfg_unit #(
    parameter int XLEN = 32,
    parameter int VLEN = 128,
    parameter int ELEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid_i,
    input  logic [31:0]     instr_i,
    input  logic [XLEN-1:0] rs1_val_i,
    input  logic [XLEN-1:0] rs2_val_i,
    output logic            cfg_hit_o,
    output logic            rd_we_o,
    output logic [4:0]      rd_idx_o,
    output logic [XLEN-1:0] rd_wdata_o,
    output logic [XLEN-1:0] vl_o,
    output logic [XLEN-1:0] vtype_o
);
    localparam logic [XLEN-1:0] VT_BAD = {1'b1, {(XLEN-1){1'b0}}};

    logic [XLEN-1:0] avl;
    logic [XLEN-1:0] req_vtype;
    logic [XLEN-1:0] vlmax;
    logic [XLEN-1:0] new_vtype;
    logic            legal;

    vcfg_decode #(.XLEN(XLEN)) u_decode (
        .instr_i     (instr_i),
        .rs1_val_i   (rs1_val_i),
        .rs2_val_i   (rs2_val_i),
        .cur_vl_i    (vl_o),
        .hit_o       (cfg_hit_o),
        .avl_o       (avl),
        .req_vtype_o (req_vtype),
        .rd_idx_o    (rd_idx_o)
    );

    vcfg_vlmax #(.XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN)) u_vlmax (
        .vtype_hi_i (req_vtype[XLEN-1:8]),
        .vsew_i     (req_vtype[5:3]),
        .vlmul_i    (req_vtype[2:0]),
        .legal_o    (legal),
        .vlmax_o    (vlmax)
    );

    // Clamp the AVL to VLMAX, or force the unsupported result.
    always_comb begin
        if (legal) begin
            new_vtype  = req_vtype;
            rd_wdata_o = (avl < vlmax) ? avl : vlmax;
        end else begin
            new_vtype  = VT_BAD;
            rd_wdata_o = '0;
        end
    end

    assign rd_we_o = valid_i && cfg_hit_o;

    vcfg_state #(.XLEN(XLEN)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (rd_we_o),
        .vl_d_i    (rd_wdata_o),
        .vtype_d_i (new_vtype),
        .vl_q_o    (vl_o),
        .vtype_q_o (vtype_o)
    );
endmodule

// File: rtl/vcfg_unit_chk.sv
// Property checker for vcfg_unit, attached by bind.
module vcfg_unit_chk #(
    parameter int XLEN = 32,
    parameter int VLEN = 128
) (
    input logic            clk,
    input logic            rst_n,
    input logic            valid_i,
    input logic            cfg_hit_i,
    input logic [1:0]      form_hi_i,
    input logic [4:0]      rs1_idx_i,
    input logic [4:0]      rd_idx_i,
    input logic [XLEN-1:0] rd_wdata_i,
    input logic [XLEN-1:0] vl_i,
    input logic            vtype_msb_i
);
    assert_bad_fmt_zero_vl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vtype_msb_i |-> (vl_i == '0));

    assert_commit_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && cfg_hit_i) |=> (vl_i == $past(rd_wdata_i)));

    assert_no_change_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_i && cfg_hit_i) |=> ($stable(vl_i) && $stable(vtype_msb_i)));

    assert_keep_not_grow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_hit_i && form_hi_i != 2'b11 && rs1_idx_i == 5'd0 && rd_idx_i == 5'd0)
        |-> (rd_wdata_i <= vl_i));

    assert_imm_avl_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_hit_i && form_hi_i == 2'b11) |-> (rd_wdata_i <= XLEN'(31)));

    assert_len_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vl_i <= XLEN'(VLEN));
endmodule

bind vcfg_unit vcfg_unit_chk #(.XLEN(XLEN), .VLEN(VLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (valid_i),
    .cfg_hit_i   (cfg_hit_o),
    .form_hi_i   (instr_i[31:30]),
    .rs1_idx_i   (instr_i[19:15]),
    .rd_idx_i    (instr_i[11:7]),
    .rd_wdata_i  (rd_wdata_o),
    .vl_i        (vl_o),
    .vtype_msb_i (vtype_o[XLEN-1])
);

// File: tb/vcfg_unit_bench.sv
`timescale 1ns/1ps
module vcfg_unit_bench;
    localparam int VLEN = 128;
    localparam int ELEN = 32;
    localparam logic [31:0] VT_BAD = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [31:0] rs1_val_i = '0;
    logic [31:0] rs2_val_i = '0;
    logic        cfg_hit_o, rd_we_o;
    logic [4:0]  rd_idx_o;
    logic [31:0] rd_wdata_o, vl_o, vtype_o;

    int checks = 0;
    int fails = 0;
    logic [31:0] m_vl = '0;
    logic [31:0] m_vt = VT_BAD;

    always #2 clk = ~clk;

    vcfg_unit #(.XLEN(32), .VLEN(VLEN), .ELEN(ELEN)) u_vcfg_unit (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
        .rs1_val_i(rs1_val_i), .rs2_val_i(rs2_val_i), .cfg_hit_o(cfg_hit_o),
        .rd_we_o(rd_we_o), .rd_idx_o(rd_idx_o), .rd_wdata_o(rd_wdata_o),
        .vl_o(vl_o), .vtype_o(vtype_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_ri(input logic [4:0] rd, input logic [4:0] rs1, input logic [10:0] z);
        return {1'b0, z, rs1, 3'b111, rd, 7'b1010111};
    endfunction
    function automatic logic [31:0] enc_ii(input logic [4:0] rd, input logic [4:0] u, input logic [9:0] z);
        return {2'b11, z, u, 3'b111, rd, 7'b1010111};
    endfunction
    function automatic logic [31:0] enc_rr(input logic [4:0] rd, input logic [4:0] rs1, input logic [4:0] rs2);
        return {7'b1000000, rs2, rs1, 3'b111, rd, 7'b1010111};
    endfunction

    // Arithmetic reference model built from R2-R9.
    task automatic model(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] cur, output bit hit, output logic [31:0] nvl,
                         output logic [31:0] nvt);
        logic [31:0] vt, avl;
        int sew, num, den, vmax;
        bit ok, regavl;
        hit = 0; vt = '0; avl = '0; regavl = 0;
        if (ins[6:0] == 7'b1010111 && ins[14:12] == 3'b111) begin
            if (!ins[31]) begin hit = 1; vt = {21'd0, ins[30:20]}; regavl = 1; end
            else if (ins[31:30] == 2'b11) begin hit = 1; vt = {22'd0, ins[29:20]}; avl = {27'd0, ins[19:15]}; end
            else if (ins[31:25] == 7'b1000000) begin hit = 1; vt = b; regavl = 1; end
        end
        if (regavl) begin
            if (ins[19:15] != 0) avl = a;
            else if (ins[11:7] != 0) avl = 32'hFFFF_FFFF;
            else avl = cur;
        end
        sew = 8 * (2 ** int'(vt[5:3]));
        if (vt[2:0] < 4) begin num = 2 ** int'(vt[2:0]); den = 1; end
        else begin num = 1; den = 2 ** (int'(vt[2:0]) - 4); end
        ok = (vt[31:8] == 0) && (vt[5:3] <= 3) && (vt[2:0] != 4) && (sew * den <= ELEN * num);
        vmax = (VLEN * num) / (den * sew);
        if (ok) begin nvt = vt; nvl = (avl < 32'(vmax)) ? avl : 32'(vmax); end
        else begin nvt = VT_BAD; nvl = '0; end
    endtask

    task automatic op(input string req, input logic [31:0] ins, input logic [31:0] a,
                      input logic [31:0] b, input bit v);
        bit hit;
        logic [31:0] nvl, nvt;
        @(negedge clk);
        valid_i = v; instr_i = ins; rs1_val_i = a; rs2_val_i = b;
        #1;
        model(ins, a, b, m_vl, hit, nvl, nvt);
        check({req, " hit"}, {31'd0, cfg_hit_o}, {31'd0, hit});
        check({req, " we"}, {31'd0, rd_we_o}, {31'd0, hit && v});
        if (hit) check({req, " rd_wdata"}, rd_wdata_o, nvl);
        @(posedge clk); #1;
        if (hit && v) begin m_vl = nvl; m_vt = nvt; end
        check({req, " vl"}, vl_o, m_vl);
        check({req, " vtype"}, vtype_o, m_vt);
    endtask

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] avls [17] = '{0, 1, 3, 7, 15, 16, 17, 31, 32, 33, 64, 100, 127, 128, 129, 255, 32'hFFFF_FFFF};
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 vl", vl_o, 32'd0);
        check("R11 vtype", vtype_o, VT_BAD);
        @(negedge clk); rst_n = 1'b1;

        // R6 R8 R9 R2: every width/grouping code, length set to VLMAX
        for (int s = 0; s < 8; s++)
            for (int l = 0; l < 8; l++)
                op("R6_R8_R9", enc_ri(5'd1, 5'd0, {3'd0, 1'(l), 1'(s), 3'(s), 3'(l)}), '0, '0, 1'b1);
        // R9: reserved immediate bits
        for (int k = 8; k < 11; k++)
            op("R9 rsv", enc_ri(5'd2, 5'd0, 11'(1 << k) | 11'h008), '0, '0, 1'b1);
        // R4 R9: register format, full sweep plus high bits
        for (int s = 0; s < 8; s++)
            for (int l = 0; l < 8; l++)
                op("R4_R8", enc_rr(5'd3, 5'd0, 5'd7), '0, {24'd0, 2'b10, 3'(s), 3'(l)}, 1'b1);
        op("R4_R9 msb", enc_rr(5'd3, 5'd0, 5'd7), '0, 32'h8000_0008, 1'b1);
        op("R4_R9 b20", enc_rr(5'd3, 5'd0, 5'd7), '0, 32'h0010_0000, 1'b1);
        // R5 R8: register AVL across lengths for both register forms
        for (int s = 0; s < 3; s++)
            for (int l = 0; l < 8; l++)
                foreach (avls[i]) begin
                    op("R5_R2", enc_ri(5'd4, 5'd9, {5'd0, 3'(s), 3'(l)}), avls[i], '0, 1'b1);
                    op("R5_R4", enc_rr(5'd4, 5'd9, 5'd1), avls[i], {26'd0, 3'(s), 3'(l)}, 1'b1);
                end
        // R3: immediate AVL sweep
        for (int u = 0; u < 32; u++)
            for (int l = 0; l < 8; l++)
                op("R3", enc_ii(5'd5, 5'(u), {4'd0, 3'd1, 3'(l)}), 32'hFFFF_FFFF, '0, 1'b1);
        // R7: keep length back to back while the format changes
        op("R7 set", enc_ri(5'd6, 5'd8, 11'h000), 32'd10, '0, 1'b1);
        op("R7 keep same", enc_ri(5'd0, 5'd0, 11'h000), 32'd99, '0, 1'b1);
        op("R7 keep shrink", enc_ri(5'd0, 5'd0, 11'h010), 32'd99, '0, 1'b1);
        op("R7 keep grow", enc_rr(5'd0, 5'd0, 5'd2), 32'd99, 32'h0000_0003, 1'b1);
        op("R7 set max", enc_ri(5'd6, 5'd0, 11'h003), '0, '0, 1'b1);
        op("R7 keep lmul", enc_rr(5'd0, 5'd0, 5'd2), '0, 32'h0000_0002, 1'b1);
        op("R7 keep bad", enc_ri(5'd0, 5'd0, 11'h004), '0, '0, 1'b1);
        op("R7 keep zero", enc_ri(5'd0, 5'd0, 11'h000), '0, '0, 1'b1);
        // R1: rejected words leave state alone
        op("R7 preset", enc_ri(5'd6, 5'd8, 11'h000), 32'd12, '0, 1'b1);
        op("R1 opcode", enc_ri(5'd1, 5'd0, 11'h000) ^ 32'h1, '0, '0, 1'b1);
        op("R1 funct3", enc_ri(5'd1, 5'd0, 11'h000) ^ 32'h1000, '0, '0, 1'b1);
        for (int t = 1; t < 32; t++)
            op("R1 form", {2'b10, 5'(t), 25'h0_0F_D7} | 32'h0000_7057, '0, '0, 1'b1);
        // R10: valid low has no effect
        op("R10 idle", enc_ri(5'd1, 5'd0, 11'h000), '0, '0, 1'b0);
        op("R10 idle bad", enc_ri(5'd1, 5'd0, 11'h004), '0, '0, 1'b0);
        @(negedge clk); valid_i = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule